// File: doc/BRIEF.md
# GPIO Interrupt Detector

The block watches 32 already-synchronized input pin levels. Each pin has its own 4-bit sense code, and the code picks one of five trigger conditions: rising edge, falling edge, either edge, high level or low level. When the pin's condition holds and the pin's input-enable bit is set, the pin's pending bit is set on the next clock edge. Software reads the raw pending bits and the masked pending bits over a simple 32-bit register bus. It masks and unmasks individual pins through separate set and clear addresses, and it acknowledges events by writing ones to a clear address.

The masked pending bits drive two interrupt request lines. One line covers the lower sixteen pins and the other covers the upper sixteen, so each half can be routed to its own handler. In a level mode, a pin whose level is still active after an acknowledge becomes pending again at once. An edge that arrives in the same cycle as its own acknowledge is kept pending.

Top module: `gpio_irq_detect`

## Requirements
- R1: Sense code 0x8 makes a 0-to-1 change of the pin set its pending bit, and code 0x9 does the same for a 1-to-0 change. The bit is visible in the cycle after the clock edge that follows the pin change.
- R2: Sense code 0xA sets the pending bit in every cycle the pin is 1, and code 0xB in every cycle the pin is 0. A pending bit that is cleared while its level is still active is set again at the next edge.
- R3: Sense code 0xC sets the pending bit on any change of the pin. Every other code value never sets the pin's pending bit.
- R4: The sense code of pin p sits in the register at address 0x40 + 4*(p/8), in bits [4*(p%8)+3 : 4*(p%8)]. The four sense registers are read/write.
- R5: The input-enable register at address 0x14 is read/write. A pin whose enable bit is 0 never sets its pending bit.
- R6: A write to 0x18 sets the interrupt-enable bits given by ones in the data. A write to 0x1C clears them. A read of 0x1C returns the enable mask, and a read of 0x18 or of any unmapped address returns 0.
- R7: A read of 0x20 returns the raw pending bits. A read of 0x24 returns the pending bits ANDed with the interrupt-enable mask.
- R8: A write to 0x28 clears each pending bit whose data bit is 1. If a pin's condition is detected in the same cycle, that pin's bit stays pending.
- R9: irq_lo_o is the OR of masked pending bits 15:0 and irq_hi_o is the OR of masked bits 31:16. Both lines follow the registered state with no extra delay.
- R10: After reset, every sense code, input-enable bit, interrupt-enable bit and pending bit is 0, and both request lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 32 | Synchronized pin levels |
| req_i | input | 1 | Bus access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from the address, 0 when not reading |
| irq_lo_o | output | 1 | Request line for pins 15:0 |
| irq_hi_o | output | 1 | Request line for pins 31:16 |

## Verification
A pin change applied before edge k is compared against the pin's previous level at edge k, and the pending bit holds the result after edge k. Register writes also take effect at the edge that samples them. Read data and both request lines are combinational from the registered state, so they are due within the same cycle. The bench keeps a model that advances exactly once per clock edge, using the inputs driven during that cycle. It drives inputs and compares outputs only at the falling edge, so every comparison sees the state that the preceding rising edge produced.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    SNS_RISE = 4'h8,
    SNS_FALL = 4'h9,
    SNS_HIGH = 4'hA,
    SNS_LOW  = 4'hB,
    SNS_BOTH = 4'hC
  } sense_e;

  localparam logic [ADDR_W-1:0] A_IN_EN  = 8'h14;
  localparam logic [ADDR_W-1:0] A_EN_SET = 8'h18;
  localparam logic [ADDR_W-1:0] A_EN_CLR = 8'h1C;
  localparam logic [ADDR_W-1:0] A_RAW    = 8'h20;
  localparam logic [ADDR_W-1:0] A_MSK    = 8'h24;
  localparam logic [ADDR_W-1:0] A_ACK    = 8'h28;
  localparam logic [ADDR_W-1:0] A_SNS0   = 8'h40;
endpackage

// File: rtl/gpio_irq_pin_det.sv
module gpio_irq_pin_det
  import gpio_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lvl_i,
  input  logic [CODE_W-1:0] mode_i,
  output logic              hit_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  always_comb begin
    unique case (mode_i)
      SNS_RISE: hit_o = lvl_i & ~lvl_q;
      SNS_FALL: hit_o = ~lvl_i & lvl_q;
      SNS_HIGH: hit_o = lvl_i;
      SNS_LOW:  hit_o = ~lvl_i;
      SNS_BOTH: hit_o = lvl_i ^ lvl_q;
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [N_PINS-1:0]        hit_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [N_PINS-1:0]        in_en_o,
  output logic [N_PINS-1:0]        pend_o,
  output logic [N_PINS-1:0]        ien_o,
  output logic [N_PINS*CODE_W-1:0] mode_o
);
  localparam int unsigned PER_REG = DATA_W / CODE_W;
  localparam int unsigned N_REGS  = (N_PINS + PER_REG - 1) / PER_REG;

  logic [N_PINS-1:0]             in_en_q, ien_q, pend_q, ack;
  logic [N_REGS-1:0][DATA_W-1:0] sns_q;
  logic                          wr, rd;

  assign wr  = req_i & we_i;
  assign rd  = req_i & ~we_i;
  assign ack = (wr && addr_i == A_ACK) ? wdata_i[N_PINS-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_en_q <= '0;
      ien_q   <= '0;
      pend_q  <= '0;
    end else begin
      // detection in the same cycle beats the acknowledge
      pend_q <= (pend_q & ~ack) | hit_i;
      if (wr && addr_i == A_IN_EN)  in_en_q <= wdata_i[N_PINS-1:0];
      if (wr && addr_i == A_EN_SET) ien_q   <= ien_q | wdata_i[N_PINS-1:0];
      if (wr && addr_i == A_EN_CLR) ien_q   <= ien_q & ~wdata_i[N_PINS-1:0];
    end
  end

  for (genvar r = 0; r < N_REGS; r++) begin : g_sns
    localparam logic [ADDR_W-1:0] ADDR = A_SNS0 + ADDR_W'(4 * r);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   sns_q[r] <= '0;
      else if (wr && addr_i == ADDR) sns_q[r] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        A_IN_EN: rdata_o = DATA_W'(in_en_q);
        A_EN_CLR: rdata_o = DATA_W'(ien_q);
        A_RAW:   rdata_o = DATA_W'(pend_q);
        A_MSK:   rdata_o = DATA_W'(pend_q & ien_q);
        default: rdata_o = '0;
      endcase
      for (int r = 0; r < N_REGS; r++) begin
        if (addr_i == A_SNS0 + ADDR_W'(4 * r)) rdata_o = sns_q[r];
      end
    end
  end

  assign in_en_o = in_en_q;
  assign ien_o   = ien_q;
  assign pend_o  = pend_q;
  assign mode_o  = (N_PINS * CODE_W)'(sns_q);
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_lo_o,
  output logic              irq_hi_o
);
  localparam int unsigned HALF = N_PINS / 2;

  logic [N_PINS-1:0]        det, hit, in_en, pend, ien, msk;
  logic [N_PINS*CODE_W-1:0] mode;

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    gpio_irq_pin_det u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (pin_i[p]),
      .mode_i (mode[p*CODE_W +: CODE_W]),
      .hit_o  (det[p])
    );
  end

  assign hit = det & in_en;

  gpio_irq_regs #(.N_PINS(N_PINS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .hit_i   (hit),
    .rdata_o (rdata_o),
    .in_en_o (in_en),
    .pend_o  (pend),
    .ien_o   (ien),
    .mode_o  (mode)
  );

  assign msk      = pend & ien;
  assign irq_lo_o = |msk[HALF-1:0];
  assign irq_hi_o = |msk[N_PINS-1:HALF];
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_lo_o,
  input logic              irq_hi_o,
  input logic [N_PINS-1:0] hit,
  input logic [N_PINS-1:0] in_en,
  input logic [N_PINS-1:0] pend,
  input logic [N_PINS-1:0] ien
);
  localparam int unsigned HALF = N_PINS / 2;

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_quiet_r10: assert (!irq_lo_o && !irq_hi_o && pend == '0);
  end

  p_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(in_en)) == '0));

  p_hit_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~pend & $past(hit)) == '0));

  p_ack_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_ACK) |=>
      ((pend & $past(wdata_i[N_PINS-1:0]) & ~$past(hit)) == '0));

  p_en_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_EN_SET) |=>
      ((ien & $past(wdata_i[N_PINS-1:0])) == $past(wdata_i[N_PINS-1:0])));

  p_en_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_EN_CLR) |=>
      ((ien & $past(wdata_i[N_PINS-1:0])) == '0));

  p_lines_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == A_MSK) |->
      (irq_lo_o == |rdata_o[HALF-1:0] && irq_hi_o == |rdata_o[N_PINS-1:HALF]));
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.N_PINS(N_PINS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .irq_lo_o (irq_lo_o),
  .irq_hi_o (irq_hi_o),
  .hit      (hit),
  .in_en    (in_en),
  .pend     (pend),
  .ien      (ien)
);

// File: tb/gpio_irq_detect_bench.sv
module gpio_irq_detect_bench;
  localparam int N = 32;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [31:0] pin = '0, wdata = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] rdata;
  logic        irq_lo, irq_hi;

  always #2 clk = ~clk;

  gpio_irq_detect u_gpio_irq_detect (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
  );

  int checks = 0, errors = 0;
  logic [31:0] m_prev = '0, m_pend = '0, m_ien = '0, m_in = '0;
  logic [3:0]  m_mode [N];

  function automatic logic f_hit(logic [3:0] c, logic p, logic n);
    case (c)
      4'h8: return n & ~p;
      4'h9: return ~n & p;
      4'hA: return n;
      4'hB: return ~n;
      4'hC: return n ^ p;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] f_sns(int r);
    logic [31:0] w = '0;
    for (int k = 0; k < 8; k++) w[4*k +: 4] = m_mode[8*r + k];
    return w;
  endfunction

  function automatic logic [31:0] f_read(logic [7:0] a);
    if (a == 8'h14) return m_in;
    if (a == 8'h1C) return m_ien;
    if (a == 8'h20) return m_pend;
    if (a == 8'h24) return m_pend & m_ien;
    if (a >= 8'h40 && a <= 8'h4C && a[1:0] == 2'b00) return f_sns(int'(a - 8'h40) / 4);
    return '0;
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic tick();
    logic [31:0] hit, ack;
    for (int i = 0; i < N; i++) hit[i] = m_in[i] & f_hit(m_mode[i], m_prev[i], pin[i]);
    ack = (req && we && addr == 8'h28) ? wdata : '0;
    @(posedge clk);
    m_pend = (m_pend & ~ack) | hit;
    m_prev = pin;
    if (req && we) begin
      if (addr == 8'h14) m_in = wdata;
      if (addr == 8'h18) m_ien = m_ien | wdata;
      if (addr == 8'h1C) m_ien = m_ien & ~wdata;
      if (addr >= 8'h40 && addr <= 8'h4C && addr[1:0] == 2'b00)
        for (int k = 0; k < 8; k++) m_mode[8*(int'(addr - 8'h40) / 4) + k] = wdata[4*k +: 4];
    end
    @(negedge clk);
    // R9: request lines
    chk("R9 irq_lo", 32'(irq_lo), 32'(|(m_pend[15:0] & m_ien[15:0])));
    chk("R9 irq_hi", 32'(irq_hi), 32'(|(m_pend[31:16] & m_ien[31:16])));
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    tick();
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, string rq);
    req = 1'b1; we = 1'b0; addr = a;
    #1 chk(rq, rdata, f_read(a));
    tick();
    req = 1'b0;
  endtask

  task automatic set_mode(int p, logic [3:0] c);
    logic [31:0] w = f_sns(p / 8);
    w[4*(p%8) +: 4] = c;
    wr(8'h40 + 8'(4 * (p / 8)), w);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m_mode[i] = 4'h0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R10: reset state
    chk("R10 lines", {30'd0, irq_hi, irq_lo}, 32'd0);
    rd(8'h14, "R10 in_en"); rd(8'h1C, "R10 ien"); rd(8'h20, "R10 raw");
    for (int r = 0; r < 4; r++) rd(8'h40 + 8'(4 * r), "R10 sense");

    // R4: field layout
    set_mode(0, 4'h8); set_mode(1, 4'h9); set_mode(2, 4'hA); set_mode(3, 4'hB);
    set_mode(4, 4'hC); set_mode(5, 4'h0); set_mode(6, 4'hD); set_mode(7, 4'h8);
    set_mode(20, 4'h8); set_mode(31, 4'hA);
    req = 1'b1; we = 1'b0; addr = 8'h40;
    #1 chk("R4 sense0", rdata, 32'h8D0C_BA98);
    addr = 8'h48;
    #1 chk("R4 sense2", rdata, 32'h0008_0000);
    req = 1'b0;
    rd(8'h44, "R4 sense1"); rd(8'h4C, "R4 sense3");

    pin = 32'h0000_000A;
    tick();
    wr(8'h14, 32'hFFFF_FF7F);
    rd(8'h14, "R5 in_en");
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, "R6 set reads 0");
    rd(8'h1C, "R6 mask");
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h20, "R2 low/high level idle");

    // R1: rising on pin 0, masked pin 7 gated off (R5), codes 0/0xD dead (R3)
    pin = 32'h0000_00E3;
    tick();
    req = 1'b1; we = 1'b0; addr = 8'h20;
    #1 chk("R1 rise pin0", 32'(rdata[0]), 32'd1);
    chk("R5 gated pin7", 32'(rdata[7]), 32'd0);
    chk("R3 dead codes", 32'(rdata[6:5]), 32'd0);
    req = 1'b0;
    wr(8'h28, 32'h0000_00FF);
    // R1: falling on pin 1
    pin = 32'h0000_00E5;
    tick();
    rd(8'h20, "R1 fall pin1");
    // R2: clear while pin 2 still high sets again
    wr(8'h28, 32'h0000_0004);
    req = 1'b1; we = 1'b0; addr = 8'h20;
    #1 chk("R2 level reasserts", 32'(rdata[2]), 32'd1);
    req = 1'b0;
    // R3/R8: both-edge on pin 4 together with its clear
    wr(8'h28, 32'h0000_0010);
    pin = pin ^ 32'h0000_0010;
    wr(8'h28, 32'h0000_0010);
    req = 1'b1; we = 1'b0; addr = 8'h20;
    #1 chk("R8 edge beats clear", 32'(rdata[4]), 32'd1);
    req = 1'b0;
    // R6/R7: masking
    wr(8'h1C, 32'h0000_FFFF);
    rd(8'h24, "R7 masked");
    rd(8'h1C, "R6 mask after clear");
    // R9: high half
    pin = pin | 32'h0010_0000;
    tick();
    chk("R9 hi asserted", 32'(irq_hi), 32'd1);
    chk("R9 lo masked", 32'(irq_lo), 32'd0);

    // random traffic
    for (int it = 0; it < 2000; it++) begin
      if ($urandom % 3 == 0) pin = $urandom;
      case ($urandom % 8)
        0: wr(8'h28, $urandom);
        1: wr(8'h18, $urandom);
        2: wr(8'h1C, $urandom);
        3: wr(8'h14, $urandom | 32'h0F0F_0F0F);
        4: set_mode(int'($urandom % 32), 4'(8 + $urandom % 6));
        5: rd(8'h20, "R7 raw random");
        6: rd(8'h24, "R7 masked random");
        default: rd(8'h40 + 8'(4 * ($urandom % 4)), "R4 sense random");
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule